// File: doc/BRIEF.md
# Single-Word Interrupt Aggregator

This block gathers a small group of interrupt sources and merges them into one interrupt line for a parent controller. Software controls it through one 32-bit register. The low half of the register holds one enable bit per source. The high half holds one latched status bit per source, placed exactly 16 bits above that source's enable.

A status bit is set by a rising edge on its source. It stays set until software writes a 1 to it. Each register write does two things at once: the low half of the data is loaded into the enables, and the high half clears the status bits that carry a 1. Software that wants to acknowledge one source therefore writes its current enables back together with that single status bit.

Two parameters set the number of sources and the position of the first one. Several instances can then split a single register map between them: for example 7 sources from bit 0, 6 sources from bit 0, or 2 sources from bit 4. Bits that no source uses always read as 0.

Top module: `irq_word_agg`

## Requirements
- R1: After reset, every register bit reads 0 and `irq_o` is 0.
- R2: A read returns, in one word, the enable of source k at bit SRC_OFS+k and its status at bit 16+SRC_OFS+k. Every other bit reads 0.
- R3: A 0-to-1 change on `src_i[k]`, seen at a clock edge, makes status k read 1 from that edge on. A source that stays high does not set status again once the status has been cleared.
- R4: A write with bit 16+SRC_OFS+k set clears status k at that edge. A write with that bit at 0 leaves status k unchanged.
- R5: If a rising edge on source k and a write that clears status k happen at the same edge, status k ends up set.
- R6: Every write loads enable k from bit SRC_OFS+k of the write data. Data bits outside the configured fields are ignored and read back as 0. The enables change only on a write.
- R7: A status bit is latched whether or not its enable is set. Enabling a source whose status is already set raises `irq_o` one cycle after the write.
- R8: `irq_o` is a register. At each clock edge it takes the OR over all k of (status k AND enable k) as those two bits stood before that edge.
- R9: With NUM_SRC=2 and SRC_OFS=4, the enables occupy bits 4 to 5 and the status bits occupy bits 20 to 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt sources, synchronous to clk_i |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data: enables in the low half, 1s to clear status in the high half |
| reg_rdata_o | output | 32 | Current control word (enables and status) |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
Directed patterns isolate one behaviour at a time:
- A single pulse shows the edge latching.
- A source held high shows that a cleared status does not set again.
- A write of zeros to status, compared with a write of a one, separates the "no effect" case from the clear.
- A pulse that lands on the same edge as a clear shows the set-wins priority.
- A source latched while its enable is off shows the deferred assertion once the enable is written.

Random phases on a 7-source instance at offset 0 and a 2-source instance at offset 4 mix source toggles with writes of random data. The random write data includes bits outside the configured fields. These phases compare every cycle against a reference, so they tell apart errors in field placement, in the masking of unused bits and in the timing of the output register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = REG_W / 2;
  typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] src_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q[i] <= 1'b0;
      else         src_q[i] <= src_i[i];
    end
    assign rise_o[i] = src_i[i] & ~src_q[i];
  end
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] en_wr_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] set_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] stat_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic clr_w;
    assign clr_w = wr_i & clr_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_o[i] <= 1'b0;
      else if (wr_i) en_o[i] <= en_wr_i[i];
    end

    // set has priority over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        stat_o[i] <= 1'b0;
      else if (set_i[i])  stat_o[i] <= 1'b1;
      else if (clr_w)     stat_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] stat_i,
  output logic               irq_o
);
  logic pend_any;
  assign pend_any = |(en_i & stat_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= pend_any;
  end
endmodule

// File: rtl/irq_word_agg.sv
module irq_word_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned SRC_OFS = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o
);
  localparam int unsigned EN_LSB   = SRC_OFS;
  localparam int unsigned STAT_LSB = HALF_W + SRC_OFS;
  localparam int unsigned TOP_BIT  = SRC_OFS + NUM_SRC;

  if (TOP_BIT > HALF_W) begin : g_bad_cfg
    $error("irq_word_agg: sources exceed the half word");
  end

  logic [NUM_SRC-1:0] src_rise;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] wr_en_field;
  logic [NUM_SRC-1:0] wr_clr_field;

  assign wr_en_field  = reg_wdata_i[EN_LSB +: NUM_SRC];
  assign wr_clr_field = reg_wdata_i[STAT_LSB +: NUM_SRC];

  // bits outside the configured fields are deliberately dropped
  logic unused_wdata;
  assign unused_wdata = ^(reg_wdata_i & ~({{NUM_SRC{1'b1}}, {HALF_W{1'b0}}} << SRC_OFS)
                                       & ~({{(REG_W-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}} << SRC_OFS));

  irq_rise_det #(.NUM_SRC(NUM_SRC)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (src_rise)
  );

  irq_stat_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .en_wr_i (wr_en_field),
    .clr_i   (wr_clr_field),
    .set_i   (src_rise),
    .en_o    (en_q),
    .stat_o  (stat_q)
  );

  irq_out_reg #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .stat_i (stat_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o                       = '0;
    reg_rdata_o[EN_LSB +: NUM_SRC]    = en_q;
    reg_rdata_o[STAT_LSB +: NUM_SRC]  = stat_q;
  end
endmodule

// File: rtl/irq_word_agg_chk.sv
module irq_word_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned SRC_OFS = 0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_wr_i,
  input logic [REG_W-1:0]   reg_wdata_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] rise_i,
  input logic [REG_W-1:0]   rdata_i,
  input logic               irq_i
);
  localparam reg_word_t USED_MASK =
    ({{(REG_W-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}} << SRC_OFS) |
    ({{(REG_W-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}} << (HALF_W + SRC_OFS));

  logic [NUM_SRC-1:0] en_f, st_f, wclr_f;
  assign en_f   = rdata_i[SRC_OFS +: NUM_SRC];
  assign st_f   = rdata_i[HALF_W + SRC_OFS +: NUM_SRC];
  assign wclr_f = reg_wdata_i[HALF_W + SRC_OFS +: NUM_SRC];

  // R2
  unused_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i & ~USED_MASK) == '0);

  // R8
  irq_follows_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_i == $past(|(en_f & st_f)));

  // R6
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> $stable(en_f));

  // R7
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> ($past(st_f) & ~st_f) == '0);

  // R4
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && src_i == '0) |=> (st_f & $past(wclr_f)) == '0);

  // R5
  rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> (st_f & $past(rise_i)) == $past(rise_i));
endmodule

bind irq_word_agg irq_word_agg_chk #(.NUM_SRC(NUM_SRC), .SRC_OFS(SRC_OFS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .src_i       (src_i),
  .rise_i      (src_rise),
  .rdata_i     (reg_rdata_o),
  .irq_i       (irq_o)
);

// File: tb/irq_word_agg_test.sv
module irq_word_agg_ref #(
  parameter int unsigned N   = 7,
  parameter int unsigned OFS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src,
  input  logic          wr,
  input  logic [31:0]   wdata,
  output logic [31:0]   exp_rdata,
  output logic          exp_irq
);
  logic [N-1:0] m_en, m_st, m_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_st <= '0; m_prev <= '0; exp_irq <= 1'b0;
    end else begin
      m_prev  <= src;
      exp_irq <= |(m_en & m_st);
      m_st    <= (m_st & ~(wr ? wdata[16+OFS +: N] : '0)) | (src & ~m_prev);
      if (wr) m_en <= wdata[OFS +: N];
    end
  end
  always_comb begin
    exp_rdata = '0;
    exp_rdata[OFS +: N]    = m_en;
    exp_rdata[16+OFS +: N] = m_st;
  end
endmodule

module irq_word_agg_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [6:0]  src_a = '0;
  logic        wr_a = 1'b0;
  logic [31:0] wd_a = '0;
  logic [31:0] rd_a, xrd_a;
  logic        irq_a, xirq_a;

  logic [1:0]  src_b = '0;
  logic        wr_b = 1'b0;
  logic [31:0] wd_b = '0;
  logic [31:0] rd_b, xrd_b;
  logic        irq_b, xirq_b;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  irq_word_agg #(.NUM_SRC(7), .SRC_OFS(0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_a), .reg_wr_i(wr_a),
    .reg_wdata_i(wd_a), .reg_rdata_o(rd_a), .irq_o(irq_a));

  irq_word_agg #(.NUM_SRC(2), .SRC_OFS(4)) uut_b (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_b), .reg_wr_i(wr_b),
    .reg_wdata_i(wd_b), .reg_rdata_o(rd_b), .irq_o(irq_b));

  irq_word_agg_ref #(.N(7), .OFS(0)) ref_a (
    .clk(clk), .rst_n(rst_ni), .src(src_a), .wr(wr_a), .wdata(wd_a),
    .exp_rdata(xrd_a), .exp_irq(xirq_a));

  irq_word_agg_ref #(.N(2), .OFS(4)) ref_b (
    .clk(clk), .rst_n(rst_ni), .src(src_b), .wr(wr_b), .wdata(wd_b),
    .exp_rdata(xrd_b), .exp_irq(xirq_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) cyc();
    // R1 reset state
    check("R1", rd_a, 32'h0);
    check("R1", {31'b0, irq_a}, 32'h0);
    check("R1", rd_b, 32'h0);
    rst_ni = 1'b1;
    cyc();

    // R6 enables loaded, out-of-field bits ignored
    wr_a = 1'b1; wd_a = 32'hFF80_FF7F; cyc(); wr_a = 1'b0;
    check("R6", rd_a, 32'h0000_007F);

    // R3 pulse latches, R8 irq one cycle later
    src_a = 7'h04; cyc(); src_a = '0;
    check("R3", rd_a, 32'h0004_007F);
    cyc();
    check("R8", {31'b0, irq_a}, 32'h1);

    // R4 writing 0 to status has no effect
    wr_a = 1'b1; wd_a = 32'h0000_007F; cyc(); wr_a = 1'b0;
    check("R4", rd_a, 32'h0004_007F);

    // R4 writing 1 clears, enables kept
    wr_a = 1'b1; wd_a = 32'h0004_007F; cyc(); wr_a = 1'b0;
    check("R4", rd_a, 32'h0000_007F);
    cyc();
    check("R8", {31'b0, irq_a}, 32'h0);

    // R3 held level does not re-set after clear
    src_a = 7'h04; cyc();
    check("R3", rd_a, 32'h0004_007F);
    wr_a = 1'b1; wd_a = 32'h0004_007F; cyc(); wr_a = 1'b0;
    check("R3", rd_a, 32'h0000_007F);
    cyc();
    check("R3", rd_a, 32'h0000_007F);
    src_a = '0;

    // R7 latch while disabled, then enable
    wr_a = 1'b1; wd_a = 32'h0; cyc(); wr_a = 1'b0;
    src_a = 7'h20; cyc(); src_a = '0;
    check("R7", rd_a, 32'h0020_0000);
    cyc();
    check("R7", {31'b0, irq_a}, 32'h0);
    wr_a = 1'b1; wd_a = 32'h0000_0020; cyc(); wr_a = 1'b0;
    check("R7", rd_a, 32'h0020_0020);
    check("R8", {31'b0, irq_a}, 32'h0);
    cyc();
    check("R7", {31'b0, irq_a}, 32'h1);

    // R5 set wins over same-edge clear
    src_a = 7'h02; wr_a = 1'b1; wd_a = 32'h0022_0020; cyc();
    src_a = '0; wr_a = 1'b0;
    check("R5", rd_a, 32'h0002_0020);
    wr_a = 1'b1; wd_a = 32'h007F_0000; cyc(); wr_a = 1'b0;
    check("R4", rd_a, 32'h0);

    // R9 offset configuration
    wr_b = 1'b1; wd_b = 32'hFFFF_FFFF; cyc(); wr_b = 1'b0;
    check("R9", rd_b, 32'h0000_0030);
    src_b = 2'b01; cyc(); src_b = '0;
    check("R9", rd_b, 32'h0010_0030);
    cyc();
    check("R8", {31'b0, irq_b}, 32'h1);
    src_b = 2'b10; cyc(); src_b = '0;
    check("R9", rd_b, 32'h0030_0030);

    // random phase, both configs, per-cycle comparison (R2, R8)
    for (int i = 0; i < 3000; i++) begin
      src_a = 7'($urandom);
      src_b = 2'($urandom);
      wr_a  = ($urandom % 4) == 0;
      wr_b  = ($urandom % 4) == 0;
      wd_a  = $urandom;
      wd_b  = $urandom;
      cyc();
      check("R2", rd_a, xrd_a);
      check("R8", {31'b0, irq_a}, {31'b0, xirq_a});
      check("R2", rd_b, xrd_b);
      check("R8", {31'b0, irq_b}, {31'b0, xirq_b});
    end
    finished = 1'b1;
    summary();
  end
endmodule